// File: doc/BRIEF.md
# Phase-Sampled External-Clock Timer

This block is an 8-bit up-counter, and its source is picked by a control bit. One source is the internal instruction cycle. The other is a pin. The fast oscillator clock is split into instruction cycles of four equal phases, Q1 to Q4, and each phase lasts one oscillator period. The count advances only at the Q4 phase. A pin transition can reach the counter in one of two ways. It can be taken directly, or it can first go through a binary divider that gives a symmetrical output. In both cases the signal is looked at only twice per instruction cycle, at Q2 and at Q4. As a result, a short pulse that falls between those two points is never seen. The delay from a pin edge to the new count is also bounded.

Software picks the source, the active pin edge, whether the divider is in the path, and the divide ratio. It can load the count, and a load also clears the divider. A wrap from all-ones to zero raises a sticky overflow flag, which software clears. While the pin is the timer source, the block tells the port logic to treat that pin as an input.

Top module: `phase_timer`

## Requirements
- R1: While rst_n is low, count reads 0 and ovf_flag reads 0. The first rising clk edge after reset is released acts as phase Q1, and the edges that follow act as Q2, Q3, Q4, Q1 and so on.
- R2: With src_ext=0 and ps_assign=0, count advances by exactly 1 at every Q4 edge and at no other edge.
- R3: With src_ext=0 and ps_assign=1, count advances once every 2^(ps_sel+1) Q4 edges, so ps_sel=0 gives 2 and ps_sel=7 gives 256. After a load, the first advance comes at the 2^(ps_sel+1)-th Q4 edge.
- R4: With src_ext=1 and ps_assign=0, each active pin transition adds exactly 1. Suppose the pin changes half a clock period before a rising edge acting as phase Q1, Q2, Q3 or Q4. The new count then appears after 4, 7, 6 or 5 rising edges, which is 3.5, 6.5, 5.5 or 4.5 oscillator periods. This stays within the 3 to 7 period window.
- R5: With edge_fall=0 a rising pin transition is active. With edge_fall=1 a falling pin transition is active, and rising transitions add nothing.
- R6: A pin pulse that stays high for at least 2 periods and low for at least 2 periods is always counted. A one-period pulse that starts half a period before a Q2 or a Q4 edge misses both sample points and is not counted.
- R7: With src_ext=1 and ps_assign=1, the pin feeds the divider. Starting from a load, M active transitions leave count = loaded value + floor((M + 2^ps_sel) / 2^(ps_sel+1)).
- R8: An advance from 8'hFF gives 8'h00 and sets ovf_flag. The flag stays set until ovf_clr is high at a clock edge. If a wrap and ovf_clr fall at the same edge, the flag ends up set.
- R9: When wr_en is high at an edge, count takes wr_data at that edge. This wins over any advance at the same edge, and the load also clears the divider.
- R10: pin_force_in is 1 exactly when src_ext is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External clock pin |
| src_ext | input | 1 | 1 = count pin transitions, 0 = count instruction cycles |
| edge_fall | input | 1 | 1 = falling pin transition is active |
| ps_assign | input | 1 | 1 = divider sits in the count path |
| ps_sel | input | 3 | Divide ratio code, ratio 2^(ps_sel+1) |
| wr_en | input | 1 | Load count from wr_data and clear the divider |
| wr_data | input | 8 | Value to load |
| ovf_clr | input | 1 | Clear the overflow flag |
| count | output | 8 | Timer value |
| ovf_flag | output | 1 | Sticky wrap flag |
| pin_force_in | output | 1 | Forces the shared pin to input direction |

## Verification
Two pairs of events can fall on the same edge. A wrap can arrive at the same edge as an overflow clear, and a count load can arrive at the same edge as a Q4 advance. The bench forces both cases by aligning the stimulus to a known phase, which it derives from the number of edges since reset. It issues the clear at the very Q4 edge where 8'hFF rolls over, and it issues the load at a Q4 edge while the internal source is running. The flag must then read set. The count must equal the loaded value and must advance only at the next Q4.

// File: rtl/phase_timer_pkg.sv
package phase_timer_pkg;
   typedef enum logic [1:0] {
      PH_Q1 = 2'd0,
      PH_Q2 = 2'd1,
      PH_Q3 = 2'd2,
      PH_Q4 = 2'd3
   } phase_t;

   function automatic phase_t phase_next(input phase_t p);
      return phase_t'(p + 2'd1);
   endfunction
endpackage

// File: rtl/pt_phase_gen.sv
module pt_phase_gen
   import phase_timer_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   output logic q2,
   output logic q4
);
   phase_t ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= PH_Q1;
      else        ph <= phase_next(ph);
   end

   assign q2 = (ph == PH_Q2);
   assign q4 = (ph == PH_Q4);
endmodule

// File: rtl/pt_divider.sv
module pt_divider #(
   parameter int PS_W  = 8,
   parameter int SEL_W = $clog2(PS_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [SEL_W-1:0] sel,
   output logic             tap,
   output logic             wrap
);
   localparam logic [PS_W-1:0] ONE = PS_W'(1);

   logic [PS_W-1:0] cnt;
   logic [PS_W-1:0] low_ones;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + ONE;
   end

   always_comb begin
      low_ones = ((ONE << sel) << 1) - ONE;
      tap      = cnt[sel];
      wrap     = &(cnt | ~low_ones);
   end
endmodule

// File: rtl/pt_sampler.sv
module pt_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic q2,
   input  logic q4,
   input  logic sig,
   output logic tick
);
   logic lvl;
   logic det;
   logic sample_now;
   logic new_rise;

   assign sample_now = q2 | q4;
   assign new_rise   = sample_now & sig & ~lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl <= 1'b0;
         det <= 1'b0;
      end else begin
         if (sample_now) lvl <= sig;
         if (clr)           det <= 1'b0;
         else if (q4)       det <= new_rise;
         else if (new_rise) det <= 1'b1;
      end
   end

   assign tick = q4 & det;
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
   parameter int CNT_W     = 8,
   parameter int PS_W      = 8,
   parameter int PS_ENABLE = 1,
   localparam int SEL_W    = $clog2(PS_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             src_ext,
   input  logic             edge_fall,
   input  logic             ps_assign,
   input  logic [SEL_W-1:0] ps_sel,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             pin_force_in
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_cnt
      $error("phase_timer: CNT_W must be at least 2");
   end
   if (PS_W < 2 || PS_W != (1 << SEL_W)) begin : g_bad_ps
      $error("phase_timer: PS_W must be a power of two of at least 2");
   end

   logic q2, q4;
   logic pin_x, sy, syd;
   logic tap, wrap;
   logic samp_sig, ext_tick, int_tick, adv;

   pt_phase_gen u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .q2    (q2),
      .q4    (q4)
   );

   assign pin_x = pin_in ^ edge_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sy  <= 1'b0;
         syd <= 1'b0;
      end else begin
         sy  <= pin_x;
         syd <= sy;
      end
   end

   if (PS_ENABLE != 0) begin : g_ps
      logic div_inc;
      assign div_inc = src_ext ? (sy & ~syd) : q4;
      pt_divider #(.PS_W(PS_W), .SEL_W(SEL_W)) u_div (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (wr_en),
         .inc   (div_inc),
         .sel   (ps_sel),
         .tap   (tap),
         .wrap  (wrap)
      );
   end else begin : g_no_ps
      assign tap  = sy;
      assign wrap = 1'b1;
   end

   assign samp_sig = ps_assign ? tap : sy;

   pt_sampler u_samp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_en),
      .q2    (q2),
      .q4    (q4),
      .sig   (samp_sig),
      .tick  (ext_tick)
   );

   assign int_tick = q4 & (~ps_assign | wrap);
   assign adv      = src_ext ? ext_tick : int_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         ovf_flag <= 1'b0;
      end else begin
         if (wr_en)    count <= wr_data;
         else if (adv) count <= count + 1'b1;
         if (adv && !wr_en && count == CNT_MAX) ovf_flag <= 1'b1;
         else if (ovf_clr)                      ovf_flag <= 1'b0;
      end
   end

   assign pin_force_in = src_ext;
endmodule

// File: rtl/phase_timer_chk.sv
module phase_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_data,
   input logic             ovf_clr,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             q4
);
   AST_ADV_ONLY_Q4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !q4) |=> count == $past(count)); // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1))); // R4
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> count == $past(wr_data)); // R9
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && count == {CNT_W{1'b1}}) |=> (count != '0 || ovf_flag)); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && count != {CNT_W{1'b1}}) |=> !ovf_flag); // R8
endmodule

bind phase_timer phase_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .ovf_clr  (ovf_clr),
   .count    (count),
   .ovf_flag (ovf_flag),
   .q4       (q4)
);

// File: tb/sim_phase_timer.sv
module sim_phase_timer;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_in = 1'b0;
   logic       src_ext = 1'b0;
   logic       edge_fall = 1'b0;
   logic       ps_assign = 1'b0;
   logic [2:0] ps_sel = 3'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic       ovf_clr = 1'b0;
   logic [7:0] count;
   logic       ovf_flag;
   logic       pin_force_in;

   int n_cmp = 0;
   int n_bad = 0;
   int edge_cnt = 0;
   bit done = 1'b0;

   phase_timer u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .src_ext(src_ext),
      .edge_fall(edge_fall), .ps_assign(ps_assign), .ps_sel(ps_sel),
      .wr_en(wr_en), .wr_data(wr_data), .ovf_clr(ovf_clr),
      .count(count), .ovf_flag(ovf_flag), .pin_force_in(pin_force_in)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) edge_cnt <= 0;
      else        edge_cnt <= edge_cnt + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // leave at a negedge whose following rising edge acts as phase p (0=Q1..3=Q4)
   task automatic wait_ph(input int p);
      while ((edge_cnt % 4) != p) @(negedge clk);
   endtask

   task automatic load(input int v);
      wr_en = 1'b1;
      wr_data = 8'(v);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic int lat_exp(input int p);
      case (p)
         0: return 4;
         1: return 7;
         2: return 6;
         default: return 5;
      endcase
   endfunction

   function automatic int ps_ext_exp(input int m, input int k);
      return (m + (1 << k)) / (1 << (k + 1));
   endfunction

   task automatic lat(input int p, input string req);
      int base;
      int n;
      wait_ph(p);
      base = count;
      pin_in = ~edge_fall;
      n = 0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end while (count == 8'(base) && n < 20);
      chk(req, n, lat_exp(p));
      chk(req, count, (base + 1) % 256);
      tick(4);
      pin_in = edge_fall;
      tick(8);
      chk(req, count, (base + 1) % 256);
   endtask

   initial begin
      int base;
      int seed_val;
      seed_val = $urandom(32'h5eed_0042);
      tick(3);
      chk("R1 count", count, 0);
      chk("R1 ovf", ovf_flag, 0);
      rst_n = 1'b1;

      // R10 direction override
      #1 chk("R10 int", pin_force_in, 0);
      src_ext = 1'b1;
      #1 chk("R10 ext", pin_force_in, 1);
      src_ext = 1'b0;
      tick(1);

      // R2 internal, no prescaler
      wait_ph(0);
      load(8'h10);
      tick(4 * 9);
      chk("R2", count, 8'h10 + 9);

      // R9 load at Q4 wins over advance
      wait_ph(3);
      load(8'h40);
      chk("R9 load", count, 8'h40);
      tick(4);
      chk("R9 next", count, 8'h41);

      // R3 internal with prescaler, random ratios
      ps_assign = 1'b1;
      for (int i = 0; i < 5; i++) begin
         int k;
         int w;
         int d;
         k = (i == 0) ? 7 : int'($urandom % 8);
         w = 20 + int'($urandom % 580);
         d = int'($urandom % 64);
         ps_sel = 3'(k);
         wait_ph(0);
         load(d);
         tick(4 * w);
         chk("R3", count, (d + w / (2 << k)) % 256);
      end
      ps_assign = 1'b0;

      // R8 overflow
      wait_ph(0);
      ovf_clr = 1'b1;
      tick(1);
      ovf_clr = 1'b0;
      chk("R8 cleared", ovf_flag, 0);
      wait_ph(0);
      load(8'hFE);
      wait_ph(3);
      tick(1);
      chk("R8 ff", count, 8'hFF);
      chk("R8 no flag", ovf_flag, 0);
      wait_ph(3);
      ovf_clr = 1'b1;
      tick(1);
      ovf_clr = 1'b0;
      chk("R8 wrap", count, 0);
      chk("R8 set wins", ovf_flag, 1);
      tick(8);
      chk("R8 sticky", ovf_flag, 1);
      ovf_clr = 1'b1;
      tick(1);
      ovf_clr = 1'b0;
      chk("R8 clr", ovf_flag, 0);

      // external, no prescaler
      src_ext = 1'b1;
      pin_in = 1'b0;
      edge_fall = 1'b0;
      tick(8);
      load(0);
      for (int p = 0; p < 4; p++) lat(p, "R4 latency");

      // R5 falling edge active
      edge_fall = 1'b1;
      pin_in = 1'b1;
      tick(8);
      lat(2, "R5 falling");
      edge_fall = 1'b0;
      pin_in = 1'b0;
      tick(8);

      // R6 one-period pulses that miss both sample points
      base = count;
      wait_ph(1);
      pin_in = 1'b1;
      tick(1);
      pin_in = 1'b0;
      tick(16);
      chk("R6 miss q2", count, base);
      wait_ph(3);
      pin_in = 1'b1;
      tick(1);
      pin_in = 1'b0;
      tick(16);
      chk("R6 miss q4", count, base);

      // R6 random pulses at least 2 high and 2 low at random offsets
      for (int i = 0; i < 12; i++) begin
         tick(int'($urandom % 4));
         pin_in = 1'b1;
         tick(2 + int'($urandom % 4));
         pin_in = 1'b0;
         tick(2 + int'($urandom % 4));
      end
      tick(12);
      chk("R6 wide pulses", count, (base + 12) % 256);

      // R7 external through prescaler
      ps_assign = 1'b1;
      for (int k = 0; k < 3; k++) begin
         int m;
         m = (k == 0) ? 5 : (k == 1) ? 6 : 9;
         ps_sel = 3'(k);
         tick(4);
         load(0);
         for (int j = 0; j < m; j++) begin
            pin_in = 1'b1;
            tick(4);
            pin_in = 1'b0;
            tick(4);
         end
         tick(16);
         chk("R7", count, ps_ext_exp(m, k));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule